// File: doc/BRIEF.md
# Warp Memory Request Coalescer

This block takes one memory instruction that a group of 32 lanes issues together. Each lane supplies an element index, a size code and an active bit. The block finds the aligned 128-byte segment that each active lane touches and folds together the lanes that share a segment. It then issues one transaction per distinct segment, one per cycle, over a valid/ready output. Each transaction carries the segment's byte address and a mask of the lanes it serves.

Once the last transaction of a group has been accepted, a one-cycle done pulse reports two figures: how many transactions the group needed and how many bytes the active lanes asked for. A utilisation figure follows by dividing the byte total by 128 times the transaction count. A new group is taken only while the busy flag is low, so merging never spans two groups.

Top module: `warp_coalescer`

## Requirements
- R1: A lane's byte address is its element index shifted left by its size code (code 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes). The transaction address is that value with its low 7 bits cleared.
- R2: All pending lanes that share a segment are served by a single transaction. In its lane mask, bit i stands for lane i, and every transaction carries at least one lane.
- R3: Transactions leave in the order in which their segments first appear when the lanes are scanned from lane 0 upward.
- R4: Inactive lanes take part in no transaction and appear in no mask. A group with no active lane issues nothing and completes with a count of 0.
- R5: At most one transaction is handed over per cycle, when txnValid and txnReady are both high. While txnValid is high and txnReady is low, the address and mask hold steady.
- R6: A request is taken on a clock edge where reqValid is high and busy is low. Busy is high from the cycle after that edge until the done pulse has ended, and reqValid has no effect while busy is high.
- R7: donePulse is high for exactly one cycle. That cycle directly follows the handshake of the group's last transaction (or, for an empty group, comes two cycles after acceptance). During it, doneCount gives the number of transactions and doneBytes the sum of the active lanes' sizes.
- R8: When all active lanes fall inside one segment, exactly one transaction is issued. When every lane hits a different segment, 32 are issued.
- R9: With 32 active 8-byte lanes at adjacent indices and a 128-byte-aligned start, the group needs exactly 2 transactions. The same lanes with a start that is off alignment by 64 bytes need 3.
- R10: After reset, busy, txnValid and donePulse are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | A group request is presented |
| reqActive | input | 32 | Active bit per lane |
| reqIdx | input | 32 x 24 | Element index per lane |
| reqSize | input | 32 x 2 | Size code per lane (log2 of bytes) |
| busy | output | 1 | High while a group is in progress |
| txnValid | output | 1 | A transaction is presented |
| txnReady | input | 1 | Downstream takes the transaction |
| txnAddr | output | 27 | 128-byte-aligned segment byte address |
| txnMask | output | 32 | Lanes served by this transaction |
| donePulse | output | 1 | One-cycle group completion strobe |
| doneCount | output | 6 | Transactions issued by the group |
| doneBytes | output | 9 | Bytes requested by the active lanes |

## Verification
The first transaction of a group appears just after the edge that accepts the request. Each later transaction appears just after the edge that took the one before it. The done pulse follows one edge after the final handshake, and an empty group reports two edges after acceptance. The bench keeps a behavioural model that builds the expected transaction list with a search over a queue. It advances the model on each rising edge and compares busy, txnValid, txnAddr, txnMask, donePulse and the done figures at every falling edge. Back-pressure from a pseudo-random txnReady, and reqValid held high while busy with different data, test the stall and ignore rules in the same cycle-exact way.

// File: rtl/coalesce_pkg.sv
package coalesce_pkg;
  localparam int SEG_SHIFT = 7;

  typedef struct packed {
    logic capture;
    logic advance;
  } ctrlStrobe_t;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ISSUE  = 2'd1,
    PH_REPORT = 2'd2
  } phase_t;
endpackage

// File: rtl/coalesce_lane_seg.sv
module coalesce_lane_seg
  import coalesce_pkg::*;
#(
  parameter int IDXW = 24
) (
  input  logic [IDXW-1:0]           idx,
  input  logic [1:0]                sizeCode,
  output logic [IDXW+3-SEG_SHIFT-1:0] seg,
  output logic [3:0]                laneBytes
);
  localparam int ADDRW = IDXW + 3;

  logic [ADDRW-1:0] byteAddr;

  // R1: byte address = index scaled by element size
  assign byteAddr  = {3'b000, idx} << sizeCode;
  assign seg       = byteAddr[ADDRW-1:SEG_SHIFT];
  assign laneBytes = 4'd1 << sizeCode;
endmodule

// File: rtl/coalesce_datapath.sv
module coalesce_datapath
  import coalesce_pkg::*;
#(
  parameter int LANES = 32,
  parameter int IDXW  = 24
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrobe_t                   strobe,
  input  logic [LANES-1:0]              reqActive,
  input  logic [LANES-1:0][IDXW-1:0]    reqIdx,
  input  logic [LANES-1:0][1:0]         reqSize,
  output logic                          anyLeft,
  output logic                          lastTxn,
  output logic [IDXW+3-1:0]             txnAddr,
  output logic [LANES-1:0]              txnMask,
  output logic [$clog2(LANES+1)-1:0]    doneCount,
  output logic [$clog2(LANES*8+1)-1:0]  doneBytes
);
  localparam int ADDRW = IDXW + 3;
  localparam int SEGW  = ADDRW - SEG_SHIFT;
  localparam int CNTW  = $clog2(LANES+1);
  localparam int BYTEW = $clog2(LANES*8+1);
  localparam int LIDXW = $clog2(LANES);

  logic [LANES-1:0][SEGW-1:0] newSeg;
  logic [LANES-1:0][3:0]      newBytes;
  logic [LANES-1:0][SEGW-1:0] segQ;
  logic [LANES-1:0]           pendQ;
  logic [CNTW-1:0]            countQ;
  logic [BYTEW-1:0]           bytesQ;
  logic [BYTEW-1:0]           bytesSum;
  logic [LIDXW-1:0]           leadIdx;
  logic                       leadFound;
  logic [SEGW-1:0]            leadSeg;
  logic [LANES-1:0]           matchMask;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    coalesce_lane_seg #(.IDXW(IDXW)) segGen_i (
      .idx      (reqIdx[g]),
      .sizeCode (reqSize[g]),
      .seg      (newSeg[g]),
      .laneBytes(newBytes[g])
    );
  end

  always_comb begin
    bytesSum = '0;
    for (int i = 0; i < LANES; i++) begin
      if (reqActive[i]) bytesSum = bytesSum + BYTEW'(newBytes[i]);
    end
  end

  // R3: the lowest pending lane leads the next transaction
  always_comb begin
    leadIdx   = '0;
    leadFound = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (pendQ[i] && !leadFound) begin
        leadIdx   = LIDXW'(i);
        leadFound = 1'b1;
      end
    end
  end

  assign leadSeg = segQ[leadIdx];

  // R2: every pending lane in the leader's segment rides along
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      matchMask[i] = pendQ[i] && (segQ[i] == leadSeg);
    end
  end

  assign anyLeft   = |pendQ;
  assign lastTxn   = (pendQ & ~matchMask) == '0;
  assign txnMask   = matchMask;
  assign txnAddr   = {leadSeg, {SEG_SHIFT{1'b0}}};
  assign doneCount = countQ;
  assign doneBytes = bytesQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      segQ   <= '0;
      pendQ  <= '0;
      countQ <= '0;
      bytesQ <= '0;
    end else if (strobe.capture) begin
      segQ   <= newSeg;
      pendQ  <= reqActive;
      countQ <= '0;
      bytesQ <= bytesSum;
    end else if (strobe.advance) begin
      pendQ  <= pendQ & ~matchMask;
      countQ <= countQ + CNTW'(1);
    end
  end

  // R4: the pending set only loses lanes between captures
  a_r4_pending_shrinks: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> (pendQ & ~$past(pendQ)) == '0);

  // R8: never more transactions than lanes
  a_r8_count_limit: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= CNTW'(LANES));

  // R2: a serviced transaction removes its lanes
  a_r2_lanes_retired: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> (pendQ & $past(matchMask)) == '0);
endmodule

// File: rtl/coalesce_control.sv
module coalesce_control
  import coalesce_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        txnReady,
  input  logic        anyLeft,
  input  logic        lastTxn,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        txnValid,
  output logic        donePulse
);
  phase_t phaseQ, phaseD;

  assign busy           = phaseQ != PH_IDLE;
  assign txnValid       = (phaseQ == PH_ISSUE) && anyLeft;
  assign donePulse      = phaseQ == PH_REPORT;
  assign strobe.capture = (phaseQ == PH_IDLE) && reqValid;
  assign strobe.advance = txnValid && txnReady;

  always_comb begin
    phaseD = phaseQ;
    unique case (phaseQ)
      PH_IDLE:   if (reqValid) phaseD = PH_ISSUE;
      PH_ISSUE:  if (!anyLeft || (strobe.advance && lastTxn)) phaseD = PH_REPORT;
      PH_REPORT: phaseD = PH_IDLE;
      default:   phaseD = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phaseQ <= PH_IDLE;
    else       phaseQ <= phaseD;
  end

  // R7: completion follows the final handshake directly
  a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rstN)
    (txnValid && txnReady && lastTxn) |=> donePulse);

  // R7: the done strobe lasts a single cycle
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  // R6: a taken request raises busy
  a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy) |=> busy);
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
  import coalesce_pkg::*;
#(
  parameter int LANES = 32,
  parameter int IDXW  = 24
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          reqValid,
  input  logic [LANES-1:0]              reqActive,
  input  logic [LANES-1:0][IDXW-1:0]    reqIdx,
  input  logic [LANES-1:0][1:0]         reqSize,
  output logic                          busy,
  output logic                          txnValid,
  input  logic                          txnReady,
  output logic [IDXW+3-1:0]             txnAddr,
  output logic [LANES-1:0]              txnMask,
  output logic                          donePulse,
  output logic [$clog2(LANES+1)-1:0]    doneCount,
  output logic [$clog2(LANES*8+1)-1:0]  doneBytes
);
  ctrlStrobe_t strobe;
  logic        anyLeft;
  logic        lastTxn;

  coalesce_control ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .txnReady (txnReady),
    .anyLeft  (anyLeft),
    .lastTxn  (lastTxn),
    .strobe   (strobe),
    .busy     (busy),
    .txnValid (txnValid),
    .donePulse(donePulse)
  );

  coalesce_datapath #(.LANES(LANES), .IDXW(IDXW)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqActive(reqActive),
    .reqIdx   (reqIdx),
    .reqSize  (reqSize),
    .anyLeft  (anyLeft),
    .lastTxn  (lastTxn),
    .txnAddr  (txnAddr),
    .txnMask  (txnMask),
    .doneCount(doneCount),
    .doneBytes(doneBytes)
  );

  // R5: a stalled transaction keeps its contents
  a_r5_hold_on_stall: assert property (@(posedge clk) disable iff (!rstN)
    (txnValid && !txnReady) |=> txnValid && $stable(txnAddr) && $stable(txnMask));

  // R6: nothing is issued outside a group
  a_r6_valid_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    txnValid |-> busy);

  // R2: every transaction serves at least one lane
  a_r2_mask_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    txnValid |-> $countones(txnMask) >= 1);
endmodule

// File: tb/warp_coalescer_tb_top.sv
`timescale 1ns/1ps
module warp_coalescer_tb_top;
  localparam int LANES = 32;
  localparam int IDXW  = 24;

  logic                       clk = 1'b0;
  logic                       rstN = 1'b0;
  logic                       reqValid = 1'b0;
  logic [LANES-1:0]           reqActive = '0;
  logic [LANES-1:0][IDXW-1:0] reqIdx = '0;
  logic [LANES-1:0][1:0]      reqSize = '0;
  logic                       txnReady = 1'b1;
  logic                       busy, txnValid, donePulse;
  logic [IDXW+2:0]            txnAddr;
  logic [LANES-1:0]           txnMask;
  logic [5:0]                 doneCount;
  logic [8:0]                 doneBytes;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  int readyMode = 0;
  logic [15:0] lfsr = 16'hACE1;

  // behavioural reference state
  int        mPhase = 0;
  longint    qAddr[$];
  longint    qMask[$];
  int        mCount = 0;
  int        mBytes = 0;
  int        lastCount = -1;

  always #2.5 clk = ~clk;

  warp_coalescer #(.LANES(LANES), .IDXW(IDXW)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqActive(reqActive),
    .reqIdx(reqIdx), .reqSize(reqSize), .busy(busy), .txnValid(txnValid),
    .txnReady(txnReady), .txnAddr(txnAddr), .txnMask(txnMask),
    .donePulse(donePulse), .doneCount(doneCount), .doneBytes(doneBytes)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: build the transaction list with a search per lane
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPhase = 0; qAddr.delete(); qMask.delete(); mCount = 0;
    end else begin
      case (mPhase)
        0: if (reqValid) begin
          qAddr.delete(); qMask.delete(); mCount = 0; mBytes = 0;
          for (int i = 0; i < LANES; i++) begin
            if (reqActive[i]) begin
              longint a;
              int hit;
              a = (longint'(reqIdx[i]) << reqSize[i]) & ~longint'(127);
              mBytes += (1 << reqSize[i]);
              hit = -1;
              foreach (qAddr[k]) if (hit < 0 && qAddr[k] == a) hit = k;
              if (hit >= 0) qMask[hit] = qMask[hit] | (longint'(1) << i);
              else begin qAddr.push_back(a); qMask.push_back(longint'(1) << i); end
            end
          end
          mPhase = 1;
        end
        1: begin
          if (qAddr.size() == 0) mPhase = 2;
          else if (txnReady) begin
            void'(qAddr.pop_front()); void'(qMask.pop_front());
            mCount++;
            if (qAddr.size() == 0) mPhase = 2;
          end
        end
        default: mPhase = 0;
      endcase
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      bit expValid;
      expValid = (mPhase == 1) && (qAddr.size() != 0);
      check(busy == (mPhase != 0), "R6 busy", busy, mPhase != 0);
      check(txnValid == expValid, "R5 txnValid", txnValid, expValid);
      if (expValid && txnValid) begin
        check(txnAddr == qAddr[0], "R1/R3 txnAddr", txnAddr, qAddr[0]);
        check(txnMask == qMask[0][LANES-1:0], "R2/R4 txnMask", txnMask, qMask[0]);
      end
      check(donePulse == (mPhase == 2), "R7 donePulse", donePulse, mPhase == 2);
      if (donePulse && mPhase == 2) begin
        check(doneCount == mCount, "R7 doneCount", doneCount, mCount);
        check(doneBytes == mBytes, "R7 doneBytes", doneBytes, mBytes);
        lastCount = doneCount;
      end
    end
  end

  // downstream readiness
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    txnReady <= (readyMode == 0) ? 1'b1 : lfsr[0];
  end

  task automatic runGroup(input string tag, input int expCount, input bit junkWhileBusy);
    @(negedge clk);
    while (busy) @(negedge clk);
    lastCount = -1;
    reqValid = 1'b1;
    @(negedge clk);
    if (junkWhileBusy) begin
      // R6: a different request presented while busy must be ignored
      for (int i = 0; i < LANES; i++) reqIdx[i] = IDXW'(i * 977 + 5);
      reqActive = ~reqActive;
      @(negedge clk);
    end
    reqValid = 1'b0;
    while (busy) @(negedge clk);
    if (expCount >= 0)
      check(lastCount == expCount, tag, lastCount, expCount);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(busy == 1'b0, "R10 busy in reset", busy, 0);
    check(txnValid == 1'b0, "R10 txnValid in reset", txnValid, 0);
    check(donePulse == 1'b0, "R10 donePulse in reset", donePulse, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && txnValid == 1'b0, "R10 idle after reset", {busy, txnValid}, 0);

    // R8: one segment, 32 lanes of 4 bytes
    reqActive = '1;
    for (int i = 0; i < LANES; i++) begin reqIdx[i] = IDXW'(i); reqSize[i] = 2'd2; end
    runGroup("R8 single segment count", 1, 1'b0);

    // R8: every lane its own segment
    for (int i = 0; i < LANES; i++) begin reqIdx[i] = IDXW'(16 * i); reqSize[i] = 2'd3; end
    runGroup("R8 all distinct count", 32, 1'b0);

    // R9: adjacent aligned 8-byte lanes
    for (int i = 0; i < LANES; i++) reqIdx[i] = IDXW'(32 + i);
    runGroup("R9 aligned 8-byte count", 2, 1'b0);
    for (int i = 0; i < LANES; i++) reqIdx[i] = IDXW'(8 + i);
    runGroup("R9 misaligned 8-byte count", 3, 1'b0);

    // R3: descending segments per 4-lane stripe
    for (int i = 0; i < LANES; i++) begin reqIdx[i] = IDXW'(128 * (3 - i % 4)); reqSize[i] = 2'd0; end
    runGroup("R3 stripe order count", 4, 1'b0);

    // R4: no active lane
    reqActive = '0;
    runGroup("R4 empty group count", 0, 1'b0);

    // R5: back-pressure on the distinct-segment pattern
    readyMode = 1;
    reqActive = '1;
    for (int i = 0; i < LANES; i++) begin reqIdx[i] = IDXW'(16 * i); reqSize[i] = 2'd3; end
    runGroup("R5 stalled distinct count", 32, 1'b0);

    // R4/R1: mixed sizes with gaps, and R6 ignore while busy
    reqActive = 32'hA5A5F00F;
    for (int i = 0; i < LANES; i++) begin reqIdx[i] = IDXW'((i * 37) % 50 + 60 * (i / 8)); reqSize[i] = 2'(i % 4); end
    runGroup("R4 mixed pattern", -1, 1'b1);

    reqActive = 32'h0000_8001;
    for (int i = 0; i < LANES; i++) begin reqIdx[i] = IDXW'(i * 3); reqSize[i] = 2'd1; end
    runGroup("R6 ignore while busy count", 1, 1'b1);

    reqActive = '0;
    runGroup("R6 empty group with junk", 0, 1'b1);

    readyMode = 0;
    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule